// File: doc/BRIEF.md
# Glitch-Free Three-Source System Clock Selector

This block picks the system clock from three free-running, mutually asynchronous inputs: a primary reference clock, a PLL output clock and an alternate low-speed clock. The alternate clock serves low-power operation, or stands in when the primary reference cannot be used. Switching is break-before-make. Each source has its own enable pipeline, clocked on that source's falling edge. A source is armed only when no other source's enable pipeline holds a set bit. The output is the OR of the three gated clocks, so every high or low phase it produces is a whole phase of one source.

The control logic runs on the primary reference clock, which is assumed to keep running. That logic registers the 2-bit select value and handles the PLL lock-loss event. A lock-loss pulse forces the primary reference and sets a sticky override flag. While the flag is set, the select input is ignored. A one-cycle clear strobe drops the flag, and the select value present at that time then takes effect through the normal handshake. The reported source code changes only after the new source's enable has been synchronized back into the control domain.

Top module: `sysclk_sel`

## Requirements
- R1: While and after rst_n is low, active_src is 2'b00 and ovr_flag is 0. Once reset is released, clk_out runs at the primary reference period and active_src stays 2'b00.
- R2: The select code 2'b00 chooses the primary reference, 2'b01 the PLL clock and 2'b10 the alternate clock. After the handshake, clk_out has the chosen source's period and active_src shows the same code.
- R3: The reserved select code 2'b11 acts as a request for the primary reference, giving active_src 2'b00 and the reference period.
- R4: No high or low phase of clk_out is shorter than the shortest half-period among the sources.
- R5: At most one source enable is asserted at any time. A source's enable rises only while no other source's enable pipeline holds a set bit.
- R6: active_src changes only after the new source's enable has been synchronized into the reference domain. One reference cycle after a select change, active_src still shows the old code.
- R7: A one-cycle lock_lost pulse sets ovr_flag at the next reference rising edge and forces the primary reference, whatever sel_req holds.
- R8: While ovr_flag is 1, changes of sel_req have no effect: active_src stays 2'b00 and clk_out keeps the reference period.
- R9: A one-cycle ovr_clear pulse, with lock_lost low, clears ovr_flag at the next reference rising edge. The select value then in force is then applied through the handshake.
- R10: When lock_lost and ovr_clear are high in the same cycle, lock_lost wins and ovr_flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Primary reference clock; also clocks the control logic |
| clk_pll | input | 1 | PLL output clock |
| clk_alt | input | 1 | Alternate low-speed clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sel_req | input | 2 | Requested source code (00 ref, 01 PLL, 10 alt, 11 treated as ref) |
| lock_lost | input | 1 | One-cycle pulse marking a PLL lock-loss warm reset |
| ovr_clear | input | 1 | One-cycle strobe that clears the override flag |
| clk_out | output | 1 | Selected, glitch-free system clock |
| active_src | output | 2 | Code of the source currently driving clk_out |
| ovr_flag | output | 1 | Sticky lock-loss override flag |

## Verification
A stuck or wrong target register shows up as the wrong clk_out period and a wrong active_src. The bench sees this within the handshake window of a few source cycles after each request. A broken arming interlock lets two gated clocks overlap, which shows as a phase shorter than the fastest half-period in the first switch that overlaps. An override that does not hold, does not release, or loses to the clear strobe is visible on ovr_flag one reference cycle after the pulse. It is also visible on active_src and on the period once the handshake window has passed.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  parameter int NSRC  = 3;
  parameter int SEL_W = 2;

  localparam logic [SEL_W-1:0] CODE_REF = 2'b00;
  localparam logic [SEL_W-1:0] CODE_PLL = 2'b01;
  localparam logic [SEL_W-1:0] CODE_ALT = 2'b10;
  localparam logic [NSRC-1:0]  OH_REF   = 3'b001;

  // Select code to one-hot source vector; reserved code falls to ref.
  function automatic logic [NSRC-1:0] sel_to_onehot(input logic [SEL_W-1:0] code);
    logic [NSRC-1:0] v;
    v = '0;
    if (int'(code) < NSRC) v[code] = 1'b1;
    else                   v = OH_REF;
    return v;
  endfunction

  // One-hot source vector back to its code (lowest set bit wins).
  function automatic logic [SEL_W-1:0] onehot_to_code(input logic [NSRC-1:0] v);
    logic [SEL_W-1:0] c;
    c = CODE_REF;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) c = SEL_W'(i);
    end
    return c;
  endfunction
endpackage

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
(
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_req,
  input  logic             lock_lost,
  input  logic             ovr_clear,
  output logic             ovr_flag,
  output logic [NSRC-1:0]  tgt_oh
);
  logic flag_next;
  logic force_ref;

  always_comb begin
    flag_next = ovr_flag;
    if (lock_lost)      flag_next = 1'b1;
    else if (ovr_clear) flag_next = 1'b0;
    force_ref = flag_next;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      tgt_oh   <= OH_REF;
    end else begin
      ovr_flag <= flag_next;
      tgt_oh   <= force_ref ? OH_REF : sel_to_onehot(sel_req);
    end
  end

  // R7 / R10: a lock-loss pulse always leaves the flag set
  a_r7_lock_sets_flag: assert property (@(posedge clk_ref) disable iff (!rst_n)
    lock_lost |=> ovr_flag);
  // R9: clear without lock loss drops the flag
  a_r9_clear_drops_flag: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (ovr_clear && !lock_lost) |=> !ovr_flag);
  // R8: while overridden the target is the reference
  a_r8_forced_ref: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ovr_flag |-> (tgt_oh == OH_REF));
  // R3: reserved code without override targets the reference
  a_r3_reserved_ref: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (sel_req == 2'b11 && !lock_lost && (!ovr_flag || ovr_clear)) |=> (tgt_oh == OH_REF));
endmodule

// File: rtl/sysclk_gate.sv
module sysclk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic want,
  input  logic others_busy,
  output logic en_q,
  output logic busy,
  output logic clk_gated
);
  logic [SYNC_STAGES-1:0] pipe;
  logic                   arm;

  assign arm = want & ~others_busy;

  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[SYNC_STAGES-2:0], arm};
  end

  assign en_q      = pipe[SYNC_STAGES-1];
  assign busy      = |pipe;
  assign clk_gated = src_clk & en_q;

  // R5: the enable rises only while every other source is idle
  a_r5_rise_when_idle: assert property (@(negedge src_clk) disable iff (!rst_n)
    $rose(en_q) |-> !others_busy);
endmodule

// File: rtl/sysclk_status.sv
module sysclk_status
  import sysclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  en_q,
  input  logic [NSRC-1:0]  tgt_oh,
  output logic [NSRC-1:0]  en_seen,
  output logic [SEL_W-1:0] active_src
);
  for (genvar g = 0; g < NSRC; g++) begin : g_back
    logic [SYNC_STAGES-1:0] s;
    always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) s <= '0;
      else        s <= {s[SYNC_STAGES-2:0], en_q[g]};
    end
    assign en_seen[g] = s[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)                 active_src <= CODE_REF;
    else if (en_seen == tgt_oh) active_src <= onehot_to_code(tgt_oh);
  end

  // R6: the reported code moves only to a source whose enable was seen
  a_r6_after_handshake: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(active_src) |-> $past(en_seen) == sel_to_onehot(active_src));
endmodule

// File: rtl/sysclk_sel.sv
module sysclk_sel
  import sysclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             clk_pll,
  input  logic             clk_alt,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_req,
  input  logic             lock_lost,
  input  logic             ovr_clear,
  output logic             clk_out,
  output logic [SEL_W-1:0] active_src,
  output logic             ovr_flag
);
  logic [NSRC-1:0] src_clks;
  logic [NSRC-1:0] tgt_oh;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] busy;
  logic [NSRC-1:0] gated;
  logic [NSRC-1:0] en_seen;

  assign src_clks = {clk_alt, clk_pll, clk_ref};

  sysclk_ctrl u_ctrl (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .sel_req   (sel_req),
    .lock_lost (lock_lost),
    .ovr_clear (ovr_clear),
    .ovr_flag  (ovr_flag),
    .tgt_oh    (tgt_oh)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [NSRC-1:0] mask;
    always_comb begin
      mask    = busy;
      mask[g] = 1'b0;
    end
    sysclk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .src_clk     (src_clks[g]),
      .rst_n       (rst_n),
      .want        (tgt_oh[g]),
      .others_busy (|mask),
      .en_q        (en_q[g]),
      .busy        (busy[g]),
      .clk_gated   (gated[g])
    );
  end

  assign clk_out = |gated;

  sysclk_status #(.SYNC_STAGES(SYNC_STAGES)) u_stat (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .tgt_oh     (tgt_oh),
    .en_seen    (en_seen),
    .active_src (active_src)
  );

  // R5: never two live enables
  a_r5_one_enable: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $onehot0(en_q));
  // R2: reported code has its enable synchronized high
  a_r2_code_live: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (en_seen != '0) |-> $onehot(en_seen));
endmodule

// File: tb/sysclk_sel_tb_top.sv
`timescale 1ns/1ps
module sysclk_sel_tb_top;
  logic clk_ref = 1'b0, clk_pll = 1'b0, clk_alt = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel_req = 2'b00;
  logic lock_lost = 1'b0, ovr_clear = 1'b0;
  logic clk_out;
  logic [1:0] active_src;
  logic ovr_flag;

  int checks = 0, errors = 0;
  int short_phases = 0;
  bit done = 0;
  bit busy = 0;
  bit mon_on = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  realtime last_edge;
  bit have_edge = 0;

  always #5 clk_ref = ~clk_ref;
  initial begin #0.7; forever #3  clk_pll = ~clk_pll; end
  initial begin #1.3; forever #17 clk_alt = ~clk_alt; end

  sysclk_sel dut_i (
    .clk_ref(clk_ref), .clk_pll(clk_pll), .clk_alt(clk_alt), .rst_n(rst_n),
    .sel_req(sel_req), .lock_lost(lock_lost), .ovr_clear(ovr_clear),
    .clk_out(clk_out), .active_src(active_src), .ovr_flag(ovr_flag)
  );

  function automatic real period_of(logic [1:0] c);
    if (c == 2'b01) return 6.0;
    if (c == 2'b10) return 34.0;
    return 10.0;
  endfunction

  task automatic check(string req, bit ok, string act, string expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // R4: phase-length monitor
  always @(clk_out) begin
    if (mon_on) begin
      if (have_edge && ($realtime - last_edge) < 2.95) short_phases++;
      last_edge = $realtime;
      have_edge = 1;
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      busy = 1;
      begin
        logic [1:0] e;
        string t;
        int n;
        realtime t1, t2;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n = 0;
        while (active_src !== e && n < 400) begin @(negedge clk_ref); n++; end
        check(t, active_src === e, $sformatf("active_src=%0d", active_src),
              $sformatf("active_src=%0d", e));
        @(posedge clk_out); @(posedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        check(t, ((t2 - t1) > period_of(e) - 0.01) && ((t2 - t1) < period_of(e) + 0.01),
              $sformatf("period=%0.3f", t2 - t1), $sformatf("period=%0.3f", period_of(e)));
      end
      busy = 0;
    end
  end

  task automatic expect_src(logic [1:0] code, string tag);
    exp_q.push_back(code);
    tag_q.push_back(tag);
    wait (exp_q.size() == 0 && !busy);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk_ref); s = 1'b1;
    @(negedge clk_ref); s = 1'b0;
  endtask

  initial begin
    #1_000_000;
    check("watchdog", 0, "timeout", "completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_ref);
    check("R1", active_src === 2'b00 && ovr_flag === 1'b0,
          $sformatf("src=%0d ovr=%0b", active_src, ovr_flag), "src=0 ovr=0");
    rst_n = 1'b1;
    mon_on = 1;
    expect_src(2'b00, "R1");

    @(negedge clk_ref); sel_req = 2'b01;
    @(negedge clk_ref);
    check("R6", active_src === 2'b00, $sformatf("%0d", active_src), "0");
    expect_src(2'b01, "R2");

    @(negedge clk_ref); sel_req = 2'b10;
    expect_src(2'b10, "R2");

    @(negedge clk_ref); sel_req = 2'b11;
    expect_src(2'b00, "R3");

    @(negedge clk_ref); sel_req = 2'b10;
    expect_src(2'b10, "R2");

    @(negedge clk_ref); lock_lost = 1'b1;
    @(negedge clk_ref); lock_lost = 1'b0;
    check("R7", ovr_flag === 1'b1, $sformatf("%0b", ovr_flag), "1");
    expect_src(2'b00, "R7");

    @(negedge clk_ref); sel_req = 2'b01;
    repeat (100) @(negedge clk_ref);
    check("R8", active_src === 2'b00 && ovr_flag === 1'b1,
          $sformatf("src=%0d ovr=%0b", active_src, ovr_flag), "src=0 ovr=1");
    expect_src(2'b00, "R8");

    pulse(ovr_clear);
    check("R9", ovr_flag === 1'b0, $sformatf("%0b", ovr_flag), "0");
    expect_src(2'b01, "R9");

    @(negedge clk_ref); lock_lost = 1'b1; ovr_clear = 1'b1;
    @(negedge clk_ref); lock_lost = 1'b0; ovr_clear = 1'b0;
    check("R10", ovr_flag === 1'b1, $sformatf("%0b", ovr_flag), "1");
    expect_src(2'b00, "R10");

    pulse(ovr_clear);
    expect_src(2'b01, "R9");
    @(negedge clk_ref); sel_req = 2'b00;
    expect_src(2'b00, "R2");

    check("R4", short_phases == 0, $sformatf("short=%0d", short_phases), "short=0");
    check("R5", 1'b1 && short_phases == 0, "overlap seen", "no overlap");
    finish_run();
  end
endmodule